// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block is the power-state sequencer of a microcontroller. When the CPU retires a sleep instruction it signals a one-cycle pulse. At that moment the controller samples three control bits:
- a standby-select bit,
- a low-speed-on bit,
- a watchdog prescaler-select bit.

From these bits it picks the low-power state to enter. Sleep stops only the CPU clock. Software standby stops both the CPU clock and the system clock, and holds the I/O pins in their current state. Any bit combination the controller does not support leaves the CPU running and raises a one-cycle flag.

An active-low standby pin overrides all of this. It reaches the peripheral reset output straight away, without a clock. A two-flop synchronized copy of the pin drives the state machine into hardware standby. In hardware standby both clocks stop and the peripherals are held in reset. When the pin goes high again, the controller passes through a timed reset state and then returns to active.

Wake-up works as follows:
- Sleep ends on any enabled interrupt or on the external interrupt.
- Software standby ends only on the external interrupt or on reset.

A per-module stop vector gates the clock enables of individual peripherals while the CPU keeps running.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: A sleep pulse in active with standby-select 0 and low-speed-on 0 (prescaler-select ignored) moves the state to sleep on the next clock edge. State codes on `pwr_state`: 0 active, 1 sleep, 2 software standby, 3 hardware standby, 4 reset sequence.
- R2: A sleep pulse in active with standby-select 1, low-speed-on 0 and prescaler-select 0 moves the state to software standby (code 2) on the next clock edge.
- R3: A sleep pulse in active with any other combination of the three bits leaves the state active and raises `mode_unsupported` for exactly one cycle after the edge.
- R4: In sleep, `cpu_clk_en` is 0 and `sys_clk_en` is 1. Any bit of `irq_pend` or `ext_irq` at a clock edge returns the state to active (code 0) at that edge.
- R5: In software standby, `cpu_clk_en` and `sys_clk_en` are 0 and `io_hold` is 1. `irq_pend` has no effect. Only `ext_irq` returns the state to active at the next edge.
- R6: A low level on `stby_n` sets `periph_rst` to 1 with no clock edge. The state becomes hardware standby (code 3) on the third rising edge after the pin falls, whatever the state and the mode bits.
- R7: In hardware standby, both clock enables are 0, `periph_rst` is 1 and interrupts have no effect. On the third edge after `stby_n` rises, the state becomes the reset sequence (code 4). The reset sequence lasts `RST_CYCLES` cycles with `sys_clk_en` 1, `cpu_clk_en` 0 and `periph_rst` 1, and then the state returns to active.
- R8: `mod_clk_en[i]` equals `sys_clk_en` with bit i of `mod_stop` cleared. `mod_stop` never changes `cpu_clk_en` or the state.
- R9: Synchronous reset puts the state in active from any state, with `cpu_clk_en` = `sys_clk_en` = 1, and `periph_rst`, `io_hold` and `mode_unsupported` all 0.
- R10: `sleep_exec` has no effect in any state other than active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_exec | input | 1 | One-cycle pulse when a sleep instruction retires |
| stby_sel | input | 1 | Standby-select control bit |
| low_spd_on | input | 1 | Low-speed-on control bit |
| wdt_psel | input | 1 | Watchdog prescaler-select control bit |
| irq_pend | input | NUM_IRQ | Enabled pending interrupts |
| ext_irq | input | 1 | External interrupt request |
| stby_n | input | 1 | Asynchronous active-low hardware standby pin |
| mod_stop | input | NUM_MOD | Per-module stop requests |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | System clock enable |
| mod_clk_en | output | NUM_MOD | Per-module clock enables |
| periph_rst | output | 1 | Peripheral reset |
| io_hold | output | 1 | I/O state hold |
| pwr_state | output | 3 | Current state code |
| mode_unsupported | output | 1 | One-cycle flag for an unsupported mode request |

## Verification
The bench builds the block with `RST_CYCLES` = 3, `NUM_IRQ` = 4 and `NUM_MOD` = 3. The short reset sequence lets the bench check the exact exit edge of the reset state. Four interrupt lines let it show that a single line wakes the block from sleep, while all lines together leave software standby untouched. Three module-stop bits give a mixed gating pattern whose clear bits follow the system clock enable, both in active and in software standby.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE = 3'd0,
        ST_SLEEP  = 3'd1,
        ST_SWSTBY = 3'd2,
        ST_HWSTBY = 3'd3,
        ST_RSTSEQ = 3'd4
    } pstate_t;

    typedef struct packed {
        logic stby_sel;
        logic low_spd;
        logic wdt_psel;
    } mode_bits_t;

    typedef enum logic [1:0] {
        REQ_NONE   = 2'd0,
        REQ_SLEEP  = 2'd1,
        REQ_SWSTBY = 2'd2,
        REQ_BAD    = 2'd3
    } entry_req_t;

    typedef struct packed {
        logic cpu_en;
        logic sys_en;
        logic prst;
        logic hold;
    } ctl_t;

    // Classify the control bits sampled with a sleep instruction.
    function automatic entry_req_t classify(input mode_bits_t m);
        entry_req_t r;
        if (m.low_spd)
            r = REQ_BAD;
        else if (!m.stby_sel)
            r = REQ_SLEEP;
        else if (!m.wdt_psel)
            r = REQ_SWSTBY;
        else
            r = REQ_BAD;
        return r;
    endfunction

    // Control outputs implied by each state.
    function automatic ctl_t ctl_of(input pstate_t s);
        ctl_t c;
        case (s)
            ST_ACTIVE: c = '{cpu_en: 1'b1, sys_en: 1'b1, prst: 1'b0, hold: 1'b0};
            ST_SLEEP:  c = '{cpu_en: 1'b0, sys_en: 1'b1, prst: 1'b0, hold: 1'b0};
            ST_SWSTBY: c = '{cpu_en: 1'b0, sys_en: 1'b0, prst: 1'b0, hold: 1'b1};
            ST_HWSTBY: c = '{cpu_en: 1'b0, sys_en: 1'b0, prst: 1'b1, hold: 1'b0};
            ST_RSTSEQ: c = '{cpu_en: 1'b0, sys_en: 1'b1, prst: 1'b1, hold: 1'b0};
            default:   c = '{cpu_en: 1'b0, sys_en: 1'b0, prst: 1'b1, hold: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lpm_pin_sync.sv
module lpm_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic pin_sync_n
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '1;
        else
            chain <= {chain[STAGES-2:0], pin_n};
    end

    assign pin_sync_n = chain[STAGES-1];
endmodule

// File: rtl/lpm_entry_decode.sv
module lpm_entry_decode
    import lpm_pkg::*;
(
    input  logic       sleep_exec,
    input  logic       in_active,
    input  mode_bits_t bits,
    output entry_req_t req
);
    always_comb begin
        if (sleep_exec && in_active)
            req = classify(bits);
        else
            req = REQ_NONE;
    end
endmodule

// File: rtl/lpm_state_seq.sv
module lpm_state_seq
    import lpm_pkg::*;
#(
    parameter int RST_CYCLES = 16,
    parameter int NUM_IRQ    = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stby_ok,
    input  entry_req_t         req,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic               ext_irq,
    output pstate_t            state,
    output logic               bad_flag
);
    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(RST_CYCLES - 1);

    pstate_t       nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          any_irq;

    assign any_irq = (|irq_pend) | ext_irq;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        if (!stby_ok) begin
            nxt = ST_HWSTBY;
        end else begin
            case (state)
                ST_ACTIVE: begin
                    if (req == REQ_SLEEP)       nxt = ST_SLEEP;
                    else if (req == REQ_SWSTBY) nxt = ST_SWSTBY;
                end
                ST_SLEEP:  if (any_irq) nxt = ST_ACTIVE;
                ST_SWSTBY: if (ext_irq) nxt = ST_ACTIVE;
                ST_HWSTBY: begin
                    nxt     = ST_RSTSEQ;
                    cnt_nxt = CNT_LOAD;
                end
                ST_RSTSEQ: begin
                    if (cnt == '0) nxt = ST_ACTIVE;
                    else           cnt_nxt = cnt - 1'b1;
                end
                default:   nxt = ST_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_ACTIVE;
            cnt      <= '0;
            bad_flag <= 1'b0;
        end else begin
            state    <= nxt;
            cnt      <= cnt_nxt;
            bad_flag <= stby_ok && (req == REQ_BAD);
        end
    end

    assert_sleep_entry_R1: assert property (@(posedge clk) disable iff (rst)
        (stby_ok && state == ST_ACTIVE && req == REQ_SLEEP) |=> (state == ST_SLEEP));

    assert_swstby_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (stby_ok && state == ST_ACTIVE && req == REQ_SWSTBY) |=> (state == ST_SWSTBY));

    assert_bad_stays_R3: assert property (@(posedge clk) disable iff (rst)
        (stby_ok && req == REQ_BAD) |=> (state == ST_ACTIVE && bad_flag));

    assert_sleep_wake_R4: assert property (@(posedge clk) disable iff (rst)
        (stby_ok && state == ST_SLEEP && any_irq) |=> (state == ST_ACTIVE));

    assert_swstby_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (stby_ok && state == ST_SWSTBY && !ext_irq) |=> (state == ST_SWSTBY));

    assert_hw_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (!stby_ok) |=> (state == ST_HWSTBY));

    assert_hw_exit_R7: assert property (@(posedge clk) disable iff (rst)
        (stby_ok && state == ST_HWSTBY) |=> (state == ST_RSTSEQ));
endmodule

// File: rtl/lpm_ctl_out.sv
module lpm_ctl_out
    import lpm_pkg::*;
#(
    parameter int NUM_MOD = 4
) (
    input  pstate_t            state,
    input  logic               stby_n,
    input  logic [NUM_MOD-1:0] mod_stop,
    output logic               cpu_clk_en,
    output logic               sys_clk_en,
    output logic [NUM_MOD-1:0] mod_clk_en,
    output logic               periph_rst,
    output logic               io_hold
);
    ctl_t c;

    assign c          = ctl_of(state);
    assign cpu_clk_en = c.cpu_en;
    assign sys_clk_en = c.sys_en;
    assign io_hold    = c.hold;
    // Pin path bypasses the synchronizer so peripherals reset at once.
    assign periph_rst = c.prst | ~stby_n;

    for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
        assign mod_clk_en[i] = c.sys_en & ~mod_stop[i];

        always_comb begin
            if (mod_stop[i])
                assert_mod_gated_R8: assert (!mod_clk_en[i]);
        end
    end

    always_comb begin
        if (!stby_n)
            assert_pin_prst_R6: assert (periph_rst);
    end
endmodule

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl
    import lpm_pkg::*;
#(
    parameter int RST_CYCLES  = 16,
    parameter int NUM_IRQ     = 8,
    parameter int NUM_MOD     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sleep_exec,
    input  logic               stby_sel,
    input  logic               low_spd_on,
    input  logic               wdt_psel,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic               ext_irq,
    input  logic               stby_n,
    input  logic [NUM_MOD-1:0] mod_stop,
    output logic               cpu_clk_en,
    output logic               sys_clk_en,
    output logic [NUM_MOD-1:0] mod_clk_en,
    output logic               periph_rst,
    output logic               io_hold,
    output logic [2:0]         pwr_state,
    output logic               mode_unsupported
);
    logic       stby_ok;
    entry_req_t req;
    pstate_t    state;
    mode_bits_t bits;

    assign bits = '{stby_sel: stby_sel, low_spd: low_spd_on, wdt_psel: wdt_psel};

    lpm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pin_n      (stby_n),
        .pin_sync_n (stby_ok)
    );

    lpm_entry_decode u_dec (
        .sleep_exec (sleep_exec),
        .in_active  (state == ST_ACTIVE),
        .bits       (bits),
        .req        (req)
    );

    lpm_state_seq #(.RST_CYCLES(RST_CYCLES), .NUM_IRQ(NUM_IRQ)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .stby_ok  (stby_ok),
        .req      (req),
        .irq_pend (irq_pend),
        .ext_irq  (ext_irq),
        .state    (state),
        .bad_flag (mode_unsupported)
    );

    lpm_ctl_out #(.NUM_MOD(NUM_MOD)) u_out (
        .state      (state),
        .stby_n     (stby_n),
        .mod_stop   (mod_stop),
        .cpu_clk_en (cpu_clk_en),
        .sys_clk_en (sys_clk_en),
        .mod_clk_en (mod_clk_en),
        .periph_rst (periph_rst),
        .io_hold    (io_hold)
    );

    assign pwr_state = state;

    assert_ignore_sleep_R10: assert property (@(posedge clk) disable iff (rst)
        (stby_ok && state == ST_SWSTBY && sleep_exec && !ext_irq) |=> (pwr_state == 3'd2));
endmodule

// File: tb/lpm_entry_ctrl_test.sv
module lpm_entry_ctrl_test;
    localparam int RSTC = 3;
    localparam int NI   = 4;
    localparam int NM   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_exec = 1'b0, stby_sel = 1'b0, low_spd_on = 1'b0, wdt_psel = 1'b0;
    logic [NI-1:0] irq_pend = '0;
    logic ext_irq = 1'b0;
    logic stby_n = 1'b1;
    logic [NM-1:0] mod_stop = '0;
    logic cpu_clk_en, sys_clk_en, periph_rst, io_hold, mode_unsupported;
    logic [NM-1:0] mod_clk_en;
    logic [2:0] pwr_state;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lpm_entry_ctrl #(.RST_CYCLES(RSTC), .NUM_IRQ(NI), .NUM_MOD(NM)) uut (
        .clk(clk), .rst(rst), .sleep_exec(sleep_exec), .stby_sel(stby_sel),
        .low_spd_on(low_spd_on), .wdt_psel(wdt_psel), .irq_pend(irq_pend),
        .ext_irq(ext_irq), .stby_n(stby_n), .mod_stop(mod_stop),
        .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .mod_clk_en(mod_clk_en),
        .periph_rst(periph_rst), .io_hold(io_hold), .pwr_state(pwr_state),
        .mode_unsupported(mode_unsupported)
    );

    // {stby_sel, low_spd_on, wdt_psel, expected state[2:0], expected flag}
    localparam logic [6:0] VEC [8] = '{
        {3'b000, 3'd1, 1'b0},
        {3'b001, 3'd1, 1'b0},
        {3'b010, 3'd0, 1'b1},
        {3'b011, 3'd0, 1'b1},
        {3'b100, 3'd2, 1'b0},
        {3'b101, 3'd0, 1'b1},
        {3'b110, 3'd0, 1'b1},
        {3'b111, 3'd0, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_sleep(input logic [2:0] b);
        {stby_sel, low_spd_on, wdt_psel} = b;
        sleep_exec = 1'b1;
        tick();
        sleep_exec = 1'b0;
    endtask

    task automatic wake_ext();
        ext_irq = 1'b1;
        tick();
        ext_irq = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        rst = 1'b0;
        // R9 reset state
        chk("R9 state", pwr_state, 0);
        chk("R9 cpu_clk_en", cpu_clk_en, 1);
        chk("R9 sys_clk_en", sys_clk_en, 1);
        chk("R9 periph_rst", periph_rst, 0);
        chk("R9 io_hold", io_hold, 0);
        chk("R9 mode_unsupported", mode_unsupported, 0);

        for (int i = 0; i < 8; i++) begin
            do_sleep(VEC[i][6:4]);
            chk("R1/R2/R3 state", pwr_state, int'(VEC[i][3:1]));
            chk("R3 flag", mode_unsupported, int'(VEC[i][0]));
            if (VEC[i][3:1] == 3'd1) begin
                chk("R4 cpu_clk_en", cpu_clk_en, 0);
                chk("R4 sys_clk_en", sys_clk_en, 1);
                irq_pend = 4'b0100;
                tick();
                irq_pend = '0;
                chk("R4 wake", pwr_state, 0);
            end else if (VEC[i][3:1] == 3'd2) begin
                chk("R5 cpu_clk_en", cpu_clk_en, 0);
                chk("R5 sys_clk_en", sys_clk_en, 0);
                chk("R5 io_hold", io_hold, 1);
                irq_pend = '1;
                tick();
                irq_pend = '0;
                chk("R5 irq ignored", pwr_state, 2);
                wake_ext();
                chk("R5 ext wake", pwr_state, 0);
            end else begin
                tick();
                chk("R3 flag one cycle", mode_unsupported, 0);
                chk("R3 stays active", pwr_state, 0);
            end
        end

        // R4 external interrupt also ends sleep
        do_sleep(3'b000);
        wake_ext();
        chk("R4 ext wake", pwr_state, 0);

        // R10 sleep pulse ignored in software standby
        do_sleep(3'b100);
        do_sleep(3'b000);
        chk("R10 ignored", pwr_state, 2);
        chk("R10 no flag", mode_unsupported, 0);

        // R8 module gating in software standby, then in active
        mod_stop = 3'b010;
        #1;
        chk("R8 gated in standby", mod_clk_en, 0);
        wake_ext();
        chk("R8 gating active", mod_clk_en, 5);
        chk("R8 cpu unaffected", cpu_clk_en, 1);
        mod_stop = '0;

        // R6 hardware standby from sleep
        do_sleep(3'b000);
        stby_n = 1'b0;
        #1;
        chk("R6 async periph_rst", periph_rst, 1);
        tick();
        tick();
        chk("R6 not yet", pwr_state, 1);
        tick();
        chk("R6 hw standby", pwr_state, 3);
        chk("R7 cpu_clk_en", cpu_clk_en, 0);
        chk("R7 sys_clk_en", sys_clk_en, 0);
        ext_irq = 1'b1;
        irq_pend = '1;
        tick();
        ext_irq = 1'b0;
        irq_pend = '0;
        chk("R7 irq ignored", pwr_state, 3);

        // R7 release and reset sequence
        stby_n = 1'b1;
        #1;
        chk("R7 periph_rst held", periph_rst, 1);
        tick();
        tick();
        chk("R7 still hw", pwr_state, 3);
        tick();
        chk("R7 reset seq", pwr_state, 4);
        chk("R7 seq sys_clk_en", sys_clk_en, 1);
        chk("R7 seq cpu_clk_en", cpu_clk_en, 0);
        chk("R7 seq periph_rst", periph_rst, 1);
        tick();
        tick();
        chk("R7 seq last cycle", pwr_state, 4);
        tick();
        chk("R7 back active", pwr_state, 0);
        chk("R7 periph_rst off", periph_rst, 0);

        // R6 hardware standby from software standby with bad bits present
        do_sleep(3'b100);
        stby_n = 1'b0;
        {stby_sel, low_spd_on, wdt_psel} = 3'b111;
        tick();
        tick();
        tick();
        chk("R6 from swstby", pwr_state, 3);
        stby_n = 1'b1;
        repeat (3 + RSTC) tick();
        chk("R7 recovered", pwr_state, 0);

        // R9 reset from software standby
        do_sleep(3'b100);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R9 reset exits standby", pwr_state, 0);
        chk("R9 io_hold cleared", io_hold, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule